// File: doc/BRIEF.md
# Dual-Bank Masked Identifier Acceptance Filter

This block decides whether a received CAN frame is kept, by comparing its packed 32-bit identifier word against two programmable filter banks. Each bank has a 32-bit code word and a 32-bit mask word. A mask bit set to 1 makes the matching identifier bit a don't-care. Each bank covers the full extended identifier and the SRR, IDE and RTR control bits.

A compare strobe latches the verdict: an accept flag and a 3-bit index naming the bank that caused acceptance. When both banks match, the lower bank wins. A 2-bit mode input selects either normal two-filter operation or a closed state that turns every frame away.

The host writes the code and mask words. The receive path asserts the strobe once per frame and reads the two latched outputs afterwards.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `accept_o` is 0 and `hit_o` is 0.
- R2: Bank k matches when every bit position i with mask bit i equal to 0 has identifier bit i equal to code bit i. This is written `((id ^ code_k) & ~mask_k) == 0`. A mask bit of 1 makes that position a don't-care.
- R3: In mode 2'b00, if both banks match, the strobe sets `accept_o`=1 and `hit_o`=0.
- R4: In mode 2'b00, if neither bank matches, the strobe sets `accept_o`=0 and leaves `hit_o` unchanged.
- R5: In mode 2'b11 (closed), and in the unused codes 2'b01 and 2'b10, the strobe sets `accept_o`=0 and leaves `hit_o` unchanged, whatever the identifier.
- R6: Both outputs change only on the clock edge at which `cmp_i` is high, and they are visible one cycle later. Without the strobe they hold, even if the identifier, code, mask or mode change.
- R7: Bank k takes its code from `code_i[32k+31:32k]` and its mask from `mask_i[32k+31:32k]`. A hit in bank k alone, in mode 2'b00, gives `accept_o`=1 and `hit_o`=k.
- R8: The identifier word is packed MSB first as ID[28:18], SRR, IDE, ID[17:0], RTR. A standard frame places ID[10:0] in bits [31:21], RTR in bit 20 and IDE in bit 19. Masking bits [18:0] makes a bank filter on the standard identifier together with its RTR and IDE bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 = two 32-bit filters; 11 = closed; 01/10 behave as closed |
| code_i | input | 64 | Acceptance code words, bank k at bits [32k+31:32k] |
| mask_i | input | 64 | Mask words, 1 = don't-care, same layout as the code words |
| id_word_i | input | 32 | Packed received identifier word |
| cmp_i | input | 1 | Compare strobe; latches the verdict |
| accept_o | output | 1 | Frame accepted by the last strobe |
| hit_o | output | 3 | Index of the bank that caused the last acceptance |

## Verification
The bench builds the block with its default two banks of 32 bits, which keeps exhaustive per-bit sweeps small. Each of the 64 bit positions of both banks is tested masked and unmasked, and all four mode codes are swept. Random code, mask and identifier triples with sparse masks then reach the miss, single-hit and double-hit cases, with the verdict computed arithmetically in the bench. Standard-layout words with masked low bits, and strobe-free changes to every input, cover the packing and hold rules.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int NBANK  = 2,
  parameter int WORD_W = 32,
  parameter int HIT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_i,
  input  logic [NBANK*WORD_W-1:0] code_i,
  input  logic [NBANK*WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0]       id_word_i,
  input  logic                    cmp_i,
  output logic                    accept_o,
  output logic [HIT_W-1:0]        hit_o
);

  localparam logic [1:0] MODE_TWO32 = 2'b00;

  logic [NBANK-1:0] bank_hit;
  logic [HIT_W-1:0] first_hit;
  logic             open_mode;
  logic             any_hit;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    wire [WORD_W-1:0] diff = (id_word_i ^ code_i[k*WORD_W +: WORD_W])
                             & ~mask_i[k*WORD_W +: WORD_W];
    assign bank_hit[k] = (diff == '0);
  end

  always_comb begin
    first_hit = '0;
    for (int k = NBANK - 1; k >= 0; k--)
      if (bank_hit[k]) first_hit = HIT_W'(k);
  end

  assign open_mode = (mode_i == MODE_TWO32);
  assign any_hit   = |bank_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      hit_o    <= '0;
    end else if (cmp_i) begin
      accept_o <= open_mode && any_hit;
      if (open_mode && any_hit) hit_o <= first_hit;
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_i |=> ($stable(accept_o) && $stable(hit_o))); // R6
  AST_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i && mode_i != MODE_TWO32) |=> (!accept_o && $stable(hit_o))); // R5
  AST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i && open_mode && !any_hit) |=> (!accept_o && $stable(hit_o))); // R4
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_i && open_mode && bank_hit[0]) |=> (accept_o && hit_o == '0)); // R3
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (int'(hit_o) < NBANK)); // R7

endmodule

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] code = '0;
  logic [63:0] mask = '0;
  logic [31:0] id = '0;
  logic        cmp = 1'b0;
  logic        acc;
  logic [2:0]  hit;

  int checks = 0;
  int fails = 0;
  bit exp_acc = 1'b0;
  logic [2:0] exp_hit = '0;

  always #5 clk = ~clk;

  can_id_filter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .code_i(code), .mask_i(mask),
    .id_word_i(id), .cmp_i(cmp), .accept_o(acc), .hit_o(hit)
  );

  function automatic bit bank_match(input logic [31:0] w, input logic [31:0] c,
                                    input logic [31:0] m);
    return ((w ^ c) & ~m) == 32'd0;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (acc !== exp_acc || hit !== exp_hit) begin
      fails++;
      $display("FAIL %s: acc=%0b hit=%0d expected acc=%0b hit=%0d",
               tag, acc, hit, exp_acc, exp_hit);
    end
  endtask

  task automatic strobe(input string tag);
    bit m0, m1;
    m0 = bank_match(id, code[31:0], mask[31:0]);
    m1 = bank_match(id, code[63:32], mask[63:32]);
    if (mode == 2'b00 && (m0 || m1)) begin
      exp_acc = 1'b1;
      exp_hit = m0 ? 3'd0 : 3'd1;
    end else begin
      exp_acc = 1'b0;
    end
    cmp = 1'b1;
    @(negedge clk);
    cmp = 1'b0;
    check(tag);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // per-bit sweep on both banks
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 32; b++) begin
        c = $urandom;
        code = {~c, ~c};
        code[k*32 +: 32] = c;
        mask = '0;
        id = c ^ (32'd1 << b);
        strobe("R2 unmasked bit mismatch");
        mask[k*32 + b] = 1'b1;
        strobe("R7 masked bit hits own bank");
        id = c;
        strobe("R2 exact match");
      end
    end

    // both banks match: lower wins
    code = {$urandom, $urandom};
    mask = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
    id = $urandom;
    strobe("R3 both banks match");
    mask[31:0] = '0;
    code[31:0] = id;
    strobe("R3 both banks match exact");

    // mode sweep
    for (int md = 0; md < 4; md++) begin
      mode = md[1:0];
      code = {id, ~id};
      mask = '0;
      strobe("R5 mode sweep bank1");
      code = {id, id};
      strobe("R5 mode sweep both");
    end
    mode = 2'b00;

    // miss keeps hit index
    code = {id, ~id};
    mask = '0;
    strobe("R4 set hit 1");
    id = ~id ^ 32'h0000_0100;
    code = {~id, ~id};
    strobe("R4 miss holds index");

    // hold without strobe
    code = {id, id};
    mask = '1;
    mode = 2'b00;
    for (int i = 0; i < 8; i++) begin
      id = $urandom;
      code = {$urandom, $urandom};
      mode = 2'(i);
      @(negedge clk);
      check("R6 hold without strobe");
    end
    mode = 2'b00;

    // standard frame layout
    for (int s = 0; s < 32; s++) begin
      logic [10:0] sid;
      sid = 11'($urandom);
      code = '0;
      code[63:53] = sid;
      code[52] = 1'b0;
      code[51] = 1'b0;
      code[31:0] = 32'h5555_5555;
      mask = '0;
      mask[50:32] = '1;
      id = {sid, 1'b0, 1'b0, 19'($urandom)};
      strobe("R8 standard data frame hits bank1");
      id[20] = 1'b1;
      strobe("R8 standard remote frame rejected");
      id[20] = 1'b0;
      id[31] = ~id[31];
      strobe("R8 standard id mismatch");
    end

    // random sweep with sparse masks
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      id = w;
      code[31:0] = w ^ ($urandom & $urandom & $urandom);
      code[63:32] = w ^ ($urandom & $urandom & $urandom);
      mask = {$urandom | $urandom, $urandom | $urandom};
      mode = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      strobe("R2 R3 R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule